// File: doc/BRIEF.md
# Pneumatic Cylinder Cycle Sequencer

This block sequences a single-acting electro-pneumatic cylinder through a programmed number of work cycles. A rising edge on the start pushbutton energises the solenoid valve, and the cylinder extends. Once the end-of-stroke limit switch closes, a dwell timer runs. When the dwell expires, the valve is released and the cylinder returns. At that same moment a return timer starts and the cycle counter advances. When the return timer expires, the valve is energised again. The run ends at the moment the counter reaches the programmed cycle count.

Both timers are on-delay timers. They advance only on cycles where the tick enable is high, so one shared prescaler sets the time base. After a run the count stays visible and a done flag is raised. The next start press clears both and begins a fresh run.

Top module: `cyl_cycle_seq`

## Requirements
- R1: After reset `valve_o`, `busy_o`, `done_o` are 0 and `count_o` is 0.
- R2: A 0-to-1 change of `start_i` while idle, with a non-zero `cycle_preset_i`, raises `valve_o` and `busy_o` on the next clock edge and clears `count_o` and `done_o`.
- R3: During the extend phase, the dwell timer counts ticks only while `stroke_end_i` is 1. `valve_o` falls on the clock edge after the dwell timer has counted `dwell_preset_i` ticks. With `tick_i` held at 1 and the limit switch closing within the first extend cycle, `valve_o` is 1 for `dwell_preset_i`+1 cycles per extend phase.
- R4: Each fall of `valve_o` increments `count_o` by exactly one.
- R5: The return timer starts counting at the fall of `valve_o`. The valve is re-energised on the clock edge after `return_preset_i` ticks have been counted. With `tick_i` held at 1, `valve_o` is 0 for `return_preset_i`+1 cycles per return phase.
- R6: When the increment makes `count_o` equal to `cycle_preset_i`, the run ends. `valve_o` and `busy_o` go to 0, `done_o` goes to 1, and `count_o` holds its value. A run therefore has exactly `cycle_preset_i` extend phases.
- R7: A start edge while idle with `cycle_preset_i` = 0 sets `done_o` at once. `valve_o` is never energised and `count_o` stays 0.
- R8: A start edge while `busy_o` is 1 is ignored. Count, phase and timing are unchanged.
- R9: While `tick_i` is 0 neither timer advances, so the current phase and `valve_o` hold.
- R10: `done_o` and `count_o` hold after a run until the next start edge, which clears both.
- R11: Asserting `rst_ni` low during a run drops `valve_o` and `busy_o` and returns the block to idle.
- R12: In the extend phase with `stroke_end_i` at 0, the dwell timer does not run. The valve stays energised for as long as the limit switch stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pushbutton, edge detected |
| stroke_end_i | input | 1 | End-of-stroke limit switch |
| tick_i | input | 1 | Timer time-base enable |
| dwell_preset_i | input | TW | Dwell ticks at end of stroke |
| return_preset_i | input | TW | Ticks allowed for the return stroke |
| cycle_preset_i | input | CW | Number of cycles per run |
| valve_o | output | 1 | Solenoid valve drive |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed |
| count_o | output | CW | Completed cycle count |

## Verification
The hardest situations to reach are a start press landing mid-run and a timer frozen part-way through its count. Both need the stimulus to follow the sequence as it moves. The bench therefore models the cylinder: it closes the limit switch one half-cycle after it sees the valve energised and opens it when the valve drops. This lets each run from the vector table close its own loop, while directed tests press start, gate `tick_i` or hold the switch open in the middle of live phases. The cycle counts per phase follow from the presets, so phase lengths, the number of extend phases and the final count are all predicted without looking inside the design.

// File: rtl/cyl_seq_pkg.sv
package cyl_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_EXTEND  = 2'd1,
    ST_RETRACT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cyl_on_delay.sv
module cyl_on_delay #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [TW-1:0] preset_i,
  output logic          q_o
);
  logic [TW-1:0] elapsed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             elapsed_q <= '0;
    else if (!en_i)                          elapsed_q <= '0;
    else if (tick_i && elapsed_q < preset_i) elapsed_q <= elapsed_q + 1'b1;
  end

  assign q_o = en_i && (elapsed_q >= preset_i);

  AST_TIMER_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(elapsed_q)); // R9
  AST_TIMER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (elapsed_q == '0)); // R12
endmodule

// File: rtl/cyl_run_counter.sv
module cyl_run_counter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] preset_i,
  output logic [CW-1:0] count_o,
  output logic          last_o
);
  localparam int XW = CW + 1;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  // next increment reaches the preset
  assign last_o  = (XW'(count_q) + XW'(1)) == XW'(preset_i);
  assign count_o = count_q;
endmodule

// File: rtl/cyl_cycle_seq.sv
module cyl_cycle_seq
  import cyl_seq_pkg::*;
#(
  parameter int TW = 8,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stroke_end_i,
  input  logic          tick_i,
  input  logic [TW-1:0] dwell_preset_i,
  input  logic [TW-1:0] return_preset_i,
  input  logic [CW-1:0] cycle_preset_i,
  output logic          valve_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] count_o
);
  seq_state_e state_q, state_d;
  logic start_q, start_rise;
  logic done_q, done_d;
  logic dwell_en, dwell_q, ret_en, ret_q;
  logic cnt_clr, cnt_inc, cnt_last;
  logic zero_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_i;
  end
  assign start_rise = start_i && !start_q;
  assign zero_run   = (cycle_preset_i == '0);

  assign dwell_en = (state_q == ST_EXTEND) && stroke_end_i;
  assign ret_en   = (state_q == ST_RETRACT);

  cyl_on_delay #(.TW(TW)) i_dwell_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(dwell_en), .tick_i(tick_i),
    .preset_i(dwell_preset_i), .q_o(dwell_q)
  );

  cyl_on_delay #(.TW(TW)) i_ret_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ret_en), .tick_i(tick_i),
    .preset_i(return_preset_i), .q_o(ret_q)
  );

  cyl_run_counter #(.CW(CW)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .preset_i(cycle_preset_i), .count_o(count_o), .last_o(cnt_last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_rise) begin
        cnt_clr = 1'b1;
        done_d  = zero_run;
        if (!zero_run) state_d = ST_EXTEND;
      end
      ST_EXTEND: if (dwell_q) begin
        cnt_inc = 1'b1;
        if (cnt_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_RETRACT;
        end
      end
      ST_RETRACT: if (ret_q) state_d = ST_EXTEND;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign valve_o = (state_q == ST_EXTEND);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valve_o) |-> (count_o == CW'($past(count_o) + 1'b1))); // R4
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (count_o < cycle_preset_i)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_rise) |=> (count_o >= $past(count_o))); // R8
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(count_o))); // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valve_o); // R6
endmodule

// File: tb/test_cyl_cycle_seq.sv
module test_cyl_cycle_seq;
  localparam int TW = 8;
  localparam int CW = 8;
  localparam int NV = 6;
  localparam int DW_T [NV] = '{0, 2, 3, 0, 5, 1};
  localparam int RT_T [NV] = '{0, 1, 0, 4, 2, 1};
  localparam int CY_T [NV] = '{1, 3, 2, 4, 1, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stroke = 1'b0, tick = 1'b1;
  logic [TW-1:0] dwell = '0, retp = '0;
  logic [CW-1:0] cyc = '0;
  logic valve, busy, done;
  logic [CW-1:0] count;
  logic plant_en = 1'b1;

  int checks = 0, errors = 0;
  int highs, lows, rises;
  logic prev_valve;

  always #2 clk = ~clk;

  cyl_cycle_seq #(.TW(TW), .CW(CW)) i_cyl_cycle_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stroke_end_i(stroke),
    .tick_i(tick), .dwell_preset_i(dwell), .return_preset_i(retp),
    .cycle_preset_i(cyc), .valve_o(valve), .busy_o(busy), .done_o(done),
    .count_o(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample outputs at negedge, then let the cylinder follow the valve
  task automatic step();
    if (valve) highs++;
    else if (busy) lows++;
    if (valve && !prev_valve) rises++;
    prev_valve = valve;
    stroke = plant_en ? valve : 1'b0;
    @(negedge clk);
  endtask

  task automatic press();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    highs = 0; lows = 0; rises = 0; prev_valve = 1'b0;
  endtask

  task automatic finish_run();
    for (int k = 0; k < 5000 && busy; k++) step();
    chk("run terminates", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valve", int'(valve), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      dwell = TW'(DW_T[v]); retp = TW'(RT_T[v]); cyc = CW'(CY_T[v]);
      press();
      chk("R2 busy after start", int'(busy), 1);
      chk("R2 done cleared", int'(done), 0);
      finish_run();
      chk("R3 valve-on cycles", highs, CY_T[v] * (DW_T[v] + 1));
      chk("R5 valve-off cycles", lows, (CY_T[v] - 1) * (RT_T[v] + 1));
      chk("R6 extend phases", rises, CY_T[v]);
      chk("R4 R6 final count", int'(count), CY_T[v]);
      chk("R6 done", int'(done), 1);
      repeat (3) step();
      chk("R10 count held", int'(count), CY_T[v]);
      chk("R10 done held", int'(done), 1);
    end

    // R8 start presses mid-run
    dwell = 8'd2; retp = 8'd2; cyc = 8'd3;
    press();
    for (int k = 0; k < 5; k++) step();
    start = 1'b1; step(); start = 1'b0; step();
    for (int k = 0; k < 4; k++) step();
    start = 1'b1; step(); start = 1'b0;
    finish_run();
    chk("R8 count unchanged by restarts", int'(count), 3);
    chk("R8 valve-on cycles", highs, 9);
    chk("R8 valve-off cycles", lows, 6);

    // R9 tick low freezes dwell timer
    tick = 1'b0;
    press();
    for (int k = 0; k < 40; k++) step();
    chk("R9 valve held", int'(valve), 1);
    chk("R9 count held", int'(count), 0);
    tick = 1'b1;
    finish_run();
    chk("R9 run completes", int'(count), 3);

    // R12 limit switch open keeps extend phase
    plant_en = 1'b0;
    press();
    for (int k = 0; k < 30; k++) step();
    chk("R12 valve held", int'(valve), 1);
    chk("R12 count", int'(count), 0);
    plant_en = 1'b1;
    finish_run();
    chk("R12 run completes", int'(count), 3);

    // R7 zero-cycle preset
    cyc = '0;
    press();
    chk("R7 done", int'(done), 1);
    chk("R7 busy", int'(busy), 0);
    chk("R7 count", int'(count), 0);
    for (int k = 0; k < 5; k++) step();
    chk("R7 no valve", highs, 0);

    // R11 reset mid-run
    cyc = 8'd4;
    press();
    for (int k = 0; k < 7; k++) step();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 valve", int'(valve), 0);
    chk("R11 busy", int'(busy), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) step();
    chk("R11 stays idle", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule